// File: doc/BRIEF.md
# Complementary Gate Deadtime Generator

This block drives three half-bridges. Each half-bridge gets one PWM reference level. The block turns that level into a high-side gate and a low-side gate that are complements of each other. Whenever a reference changes level, the pair enters a dead interval of programmable length. During that interval neither transistor of the half-bridge may conduct. When the interval ends, the gate that matches the new reference level turns on.

Several controls sit behind the generator, in this order:
- a per-pair swap that exchanges the high-side and low-side signals;
- a per-pair software override that replaces both active levels;
- a separate polarity control for each gate, applied last.

Because polarity is applied last, an inactive gate always drives the deasserted level that its polarity selects.

Top module: `gdb_top`

## Requirements
- R1: While `rst` is high, and after it falls until the first dead interval has ended, every pair's generated levels are inactive. With override off, each gate pin equals its polarity bit (inactive). The first clock after reset counts as a level change of the reference, so it starts a dead interval.
- R2: Once a pair's dead interval has ended, its high-side active level equals the reference level sampled at the last change. The low-side active level is the inverse of it.
- R3: A reference change seen at a clock edge loads that pair's `dead_len` value D. For the D clock cycles after that edge, both generated levels of the pair are inactive. After the edge D cycles later, the gate that matches the new level is active.
- R4: If the reference changes again before the dead interval ends, the counter reloads with the current D. Both levels stay inactive until D cycles after the latest change.
- R5: A `dead_len` of zero inserts no dead interval. The gates switch right after the clock edge that samples the reference change.
- R6: The two generated levels of a pair are never active at the same time.
- R7: With `swap_en[k]` high, pair k's high-side and low-side generated levels are exchanged.
- R8: With `ovr_en[k]` high, pair k's active levels come from the override value, regardless of the generator and of swap. The high-side level is `ovr_val[2k]` and the low-side level is `ovr_val[2k+1]`.
- R9: Polarity acts last. The pin is the active level XOR the polarity bit, so a polarity bit of 1 means active-low. `pol_top[k]` drives pin `gate[2k]` and `pol_bot[k]` drives pin `gate[2k+1]`.
- R10: Pairs are independent. Pair k uses only `pwm_ref[k]`, `dead_len[8k+7:8k]` and its own control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_ref | input | 3 | Reference level per pair |
| dead_len | input | 24 | Dead interval per pair in clock cycles, 8 bits each, pair k at bits 8k+7:8k |
| swap_en | input | 3 | Exchange high-side and low-side per pair |
| pol_top | input | 3 | High-side polarity per pair (1 = active-low) |
| pol_bot | input | 3 | Low-side polarity per pair (1 = active-low) |
| ovr_en | input | 3 | Select the software override for a pair |
| ovr_val | input | 6 | Override active levels; bit 2k high-side, bit 2k+1 low-side |
| gate | output | 6 | Gate pins; bit 2k high-side, bit 2k+1 low-side of pair k |

## Verification
The bench counts the length of each dead interval cycle by cycle against a bench model.
- An off-by-one counter would show up as a gate turning on one cycle early or late.
- Retriggering the reference in the middle of an interval catches a design that lets the counter run out, which would turn a transistor on too soon.
- A zero deadtime catches a design that adds a stray cycle.
- The first cycles after reset catch a design that drives the low side on straight away.

Random mixes of swap, override and polarity show whether the order is wrong, for example polarity applied before the override, which would invert the software value.

// File: rtl/gdb_pkg.sv
package gdb_pkg;

    // Active levels of one half-bridge: 1 = transistor conducts.
    typedef struct packed {
        logic top;
        logic bot;
    } gate_pair_t;

    function automatic gate_pair_t pair_swap(gate_pair_t p, logic sw);
        gate_pair_t r;
        r.top = sw ? p.bot : p.top;
        r.bot = sw ? p.top : p.bot;
        return r;
    endfunction

    function automatic gate_pair_t pair_select(gate_pair_t gen, logic use_sw,
                                               logic sw_top, logic sw_bot);
        gate_pair_t r;
        r.top = use_sw ? sw_top : gen.top;
        r.bot = use_sw ? sw_bot : gen.bot;
        return r;
    endfunction

    function automatic gate_pair_t pair_polarity(gate_pair_t p, logic inv_top,
                                                 logic inv_bot);
        gate_pair_t r;
        r.top = p.top ^ inv_top;
        r.bot = p.bot ^ inv_bot;
        return r;
    endfunction

endpackage

// File: rtl/gdb_pair_timer.sv
module gdb_pair_timer
    import gdb_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_in,
    input  logic [DT_W-1:0] dead_len,
    output gate_pair_t      gen_out
);

    logic            armed;
    logic            lvl;
    logic [DT_W-1:0] cnt;
    logic            changed;

    assign changed = !armed || (ref_in != lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            lvl   <= 1'b0;
            cnt   <= '0;
        end else if (changed) begin
            armed <= 1'b1;
            lvl   <= ref_in;
            cnt   <= dead_len;
        end else if (cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end
    end

    assign gen_out.top = armed && (cnt == '0) && lvl;
    assign gen_out.bot = armed && (cnt == '0) && !lvl;

    // R1: reset clears the counter and disarms the pair
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!armed && cnt == '0));

    // R4: any change, even during a running interval, reloads the counter
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && ref_in != lvl) |=> (cnt == $past(dead_len)));

    // R3: with a steady reference the interval counts down by one per cycle
    p_countdown_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && ref_in == lvl && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R6: never both transistors on
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        !(gen_out.top && gen_out.bot));

endmodule

// File: rtl/gdb_out_stage.sv
module gdb_out_stage
    import gdb_pkg::*;
(
    input  gate_pair_t gen_in,
    input  logic       swap_en,
    input  logic       ovr_en,
    input  logic       ovr_top,
    input  logic       ovr_bot,
    input  logic       pol_top,
    input  logic       pol_bot,
    output logic       pin_top,
    output logic       pin_bot
);

    gate_pair_t swapped;
    gate_pair_t chosen;
    gate_pair_t driven;

    always_comb begin
        swapped = pair_swap(gen_in, swap_en);
        chosen  = pair_select(swapped, ovr_en, ovr_top, ovr_bot);
        driven  = pair_polarity(chosen, pol_top, pol_bot);
    end

    assign pin_top = driven.top;
    assign pin_bot = driven.bot;

endmodule

// File: rtl/gdb_top.sv
module gdb_top
    import gdb_pkg::*;
#(
    parameter int unsigned PAIRS = 3,
    parameter int unsigned DT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PAIRS-1:0]      pwm_ref,
    input  logic [PAIRS*DT_W-1:0] dead_len,
    input  logic [PAIRS-1:0]      swap_en,
    input  logic [PAIRS-1:0]      pol_top,
    input  logic [PAIRS-1:0]      pol_bot,
    input  logic [PAIRS-1:0]      ovr_en,
    input  logic [2*PAIRS-1:0]    ovr_val,
    output logic [2*PAIRS-1:0]    gate
);

    localparam int unsigned GATES = 2 * PAIRS;

    gate_pair_t gen [PAIRS];

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        gdb_pair_timer #(.DT_W(DT_W)) u_timer (
            .clk      (clk),
            .rst      (rst),
            .ref_in   (pwm_ref[k]),
            .dead_len (dead_len[k*DT_W +: DT_W]),
            .gen_out  (gen[k])
        );

        gdb_out_stage u_out (
            .gen_in  (gen[k]),
            .swap_en (swap_en[k]),
            .ovr_en  (ovr_en[k]),
            .ovr_top (ovr_val[2*k]),
            .ovr_bot (ovr_val[2*k+1]),
            .pol_top (pol_top[k]),
            .pol_bot (pol_bot[k]),
            .pin_top (gate[2*k]),
            .pin_bot (gate[2*k+1])
        );

        // R8 and R9: an overridden pair shows the software value through its polarity
        p_override_r8: assert property (@(posedge clk) disable iff (rst)
            ovr_en[k] |-> (gate[2*k]   == (ovr_val[2*k]   ^ pol_top[k]) &&
                           gate[2*k+1] == (ovr_val[2*k+1] ^ pol_bot[k])));

        // R1: during reset an unforced pair rests at its deasserted levels
        p_reset_idle_r1: assert property (@(posedge clk)
            (rst && !ovr_en[k]) |=> (ovr_en[k] || (gate[2*k] == pol_top[k] &&
                                     gate[2*k+1] == pol_bot[k])));
    end

    if (GATES != 2 * PAIRS) begin : g_bad_width
        initial $error("gate width mismatch");
    end

endmodule

// File: tb/test_gdb_top.sv
`timescale 1ns/1ps
module test_gdb_top;

    localparam int P  = 3;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [P-1:0]    pwm_ref = '0;
    logic [P*DW-1:0] dead_len = '0;
    logic [P-1:0]    swap_en = '0;
    logic [P-1:0]    pol_top = '0;
    logic [P-1:0]    pol_bot = '0;
    logic [P-1:0]    ovr_en = '0;
    logic [2*P-1:0]  ovr_val = '0;
    logic [2*P-1:0]  gate;

    gdb_top #(.PAIRS(P), .DT_W(DW)) i_gdb_top (
        .clk(clk), .rst(rst), .pwm_ref(pwm_ref), .dead_len(dead_len),
        .swap_en(swap_en), .pol_top(pol_top), .pol_bot(pol_bot),
        .ovr_en(ovr_en), .ovr_val(ovr_val), .gate(gate)
    );

    always #2 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    done     = 1'b0;

    bit m_armed [P];
    bit m_lvl   [P];
    int m_cnt   [P];

    task automatic check(input bit ok, input string req,
                         input logic [2*P-1:0] act, input logic [2*P-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: gate=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2*P-1:0] expect_gate();
        logic [2*P-1:0] e;
        for (int k = 0; k < P; k++) begin
            bit t, b, x;
            t = m_armed[k] && m_cnt[k] == 0 && m_lvl[k];
            b = m_armed[k] && m_cnt[k] == 0 && !m_lvl[k];
            if (swap_en[k]) begin x = t; t = b; b = x; end
            if (ovr_en[k]) begin t = ovr_val[2*k]; b = ovr_val[2*k+1]; end
            e[2*k]   = t ^ pol_top[k];
            e[2*k+1] = b ^ pol_bot[k];
        end
        return e;
    endfunction

    // Predict the state after the coming edge, take the edge, then compare.
    task automatic step();
        for (int k = 0; k < P; k++) begin
            if (rst) begin
                m_armed[k] = 0; m_lvl[k] = 0; m_cnt[k] = 0;
            end else if (!m_armed[k] || pwm_ref[k] != m_lvl[k]) begin
                m_armed[k] = 1; m_lvl[k] = pwm_ref[k];
                m_cnt[k] = int'(dead_len[k*DW +: DW]);
            end else if (m_cnt[k] != 0) begin
                m_cnt[k]--;
            end
        end
        @(posedge clk);
        #1;
        check(gate == expect_gate(), tag, gate, expect_gate());
    endtask

    task automatic set_dt(input int k, input int v);
        dead_len[k*DW +: DW] = DW'(v);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, gate=%b expected done", gate);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < P; k++) begin m_armed[k] = 0; m_lvl[k] = 0; m_cnt[k] = 0; end

        // R1: reset, then first dead interval right after reset
        tag = "R1";
        for (int k = 0; k < P; k++) set_dt(k, 3);
        pol_top = 3'b010; pol_bot = 3'b100;
        #1;
        repeat (3) step();
        check(gate == {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, "R1", gate, 6'b100100);
        rst = 1'b0;
        repeat (3) step();
        check(gate == 6'b100100, "R1", gate, 6'b100100);
        step();
        pol_top = '0; pol_bot = '0;
        #0;
        check(gate == 6'b101010, "R2", gate, 6'b101010);

        // R5: zero deadtime switches on the sampling edge
        tag = "R5";
        set_dt(0, 0);
        pwm_ref[0] = 1'b1;
        step();
        check(gate[1:0] == 2'b01, "R5", gate, {gate[5:2], 2'b01});
        pwm_ref[0] = 1'b0;
        step();
        check(gate[1:0] == 2'b10, "R5", gate, {gate[5:2], 2'b10});

        // R3: exact dead interval of 4 cycles
        tag = "R3";
        set_dt(0, 4);
        pwm_ref[0] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step();
            check(gate[1:0] == 2'b00, "R3", gate, {gate[5:2], 2'b00});
        end
        step();
        check(gate[1:0] == 2'b01, "R3", gate, {gate[5:2], 2'b01});

        // R4: retrigger mid-interval reloads the count
        tag = "R4";
        pwm_ref[0] = 1'b0;
        step(); step();
        pwm_ref[0] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            step();
            check(gate[1:0] == 2'b00, "R4", gate, {gate[5:2], 2'b00});
        end
        step();
        check(gate[1:0] == 2'b01, "R4", gate, {gate[5:2], 2'b01});

        // R10: pair 1 moves, pair 2 must keep its state
        tag = "R10";
        set_dt(1, 2);
        pwm_ref[1] = 1'b1;
        repeat (3) step();
        check(gate[3:2] == 2'b01 && gate[5:4] == 2'b10, "R10", gate, {2'b10, 2'b01, gate[1:0]});

        // R7: swap exchanges the pair
        tag = "R7";
        swap_en[0] = 1'b1;
        step();
        check(gate[1:0] == 2'b10, "R7", gate, {gate[5:2], 2'b10});
        swap_en[0] = 1'b0;

        // R8: override beats generator and swap
        tag = "R8";
        ovr_en[2] = 1'b1; swap_en[2] = 1'b1; ovr_val[5:4] = 2'b01;
        step();
        check(gate[5:4] == 2'b01, "R8", gate, {2'b01, gate[3:0]});

        // R9: polarity acts after the override
        tag = "R9";
        pol_top[2] = 1'b1;
        step();
        check(gate[5:4] == 2'b00, "R9", gate, {2'b00, gate[3:0]});
        ovr_en = '0; swap_en = '0; pol_top = '0;

        // Random mix of all controls
        tag = "R2 R3 R6 R7 R8 R9 random";
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < P; k++) begin
                if ($urandom_range(0, 3) == 0) pwm_ref[k] = ~pwm_ref[k];
                if ($urandom_range(0, 15) == 0) set_dt(k, $urandom_range(0, 6));
                if ($urandom_range(0, 31) == 0) swap_en[k] = ~swap_en[k];
                if ($urandom_range(0, 31) == 0) ovr_en[k] = ~ovr_en[k];
                if ($urandom_range(0, 31) == 0) pol_top[k] = ~pol_top[k];
                if ($urandom_range(0, 31) == 0) pol_bot[k] = ~pol_bot[k];
            end
            if ($urandom_range(0, 7) == 0) ovr_val = 6'($urandom);
            if (n == 1500) rst = 1'b1;
            if (n == 1503) rst = 1'b0;
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule